// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating analog-to-digital converter. It walks the analog front end through a repeating measurement cycle of four phases: offset nulling, a fixed-length integration of the input, a timed discharge against the reference, and a clean-up phase that drains the integrator. Each phase is driven as one bit of a one-hot switch-control bus. The block samples a clocked comparator that reports the sign of the integrator output. It captures the input polarity when the input integration ends, and it counts clocks until the integrator crosses back through zero. That count is the reading, scaled so that an input equal to the reference gives `INT_CLKS` counts (10000 by default).

The reading is published with its polarity and two range flags that external logic can use to switch ranges. A one-clock valid strobe marks every new reading. A busy output covers the part of the cycle that is sensitive to the input. A run input lets a host freeze the converter: the conversion in progress is finished, and the block then parks in offset nulling with the last reading held. The comparator input is taken to be already synchronous to `clk`.

Top module: `dsadc_seq`

## Requirements
- R1: Phases always follow the order null → integrate → discharge → drain → null. `phase_oh_o` is one-hot with bit 0 = null, bit 1 = integrate, bit 2 = discharge and bit 3 = drain. Reset enters the null phase.
- R2: The integrate phase lasts exactly `INT_CLKS` clocks.
- R3: The value of `cmp_i` on the last integrate clock is latched as the polarity (1 = positive input). It is reported on `pol_o` with the reading. `ref_neg_o` is high for the whole discharge phase when the polarity is positive, and low otherwise.
- R4: The discharge phase ends on the first clock where `cmp_i` differs from the latched polarity. The reading is the number N of earlier discharge clocks, and the phase lasts N+1 clocks.
- R5: If N reaches `FULL_SCALE` with no crossing, discharge is cut off after `FULL_SCALE`+1 clocks. `ovr_o` is then 1 and `count_o` is `FULL_SCALE`+1. A reading of exactly `FULL_SCALE` is not an overrange.
- R6: `under_o` is 1 exactly when the reading is not an overrange and is below `UNDER_LIM`.
- R7: The drain phase lasts `ZI_NORM_CLKS` clocks, or `ZI_OVR_CLKS` clocks when the reading just taken was an overrange.
- R8: While running, integrate phases start exactly `CYCLE_CLKS` clocks apart. The null phase fills the rest of the cycle and is never shorter than `AZ_MIN_CLKS`. After reset it lasts exactly `AZ_MIN_CLKS`.
- R9: When `run_i` is low, the current conversion completes. The block then stays in the null phase, with the reading outputs unchanged and busy low. When `run_i` is sampled high again, integration starts on the next clock.
- R10: `busy_o` is high during the integrate and discharge phases only.
- R11: `valid_o` pulses for exactly one clock, on the first drain clock. The reading outputs change only in that clock.
- R12: During reset the phase is null, and busy, valid, reading, polarity and both flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | 1 = convert continuously, 0 = hold after the current conversion |
| cmp_i | input | 1 | Integrator sign from the comparator, 1 = positive |
| phase_oh_o | output | 4 | One-hot phase switch controls (null, integrate, discharge, drain) |
| ref_neg_o | output | 1 | Select the negative reference during discharge |
| busy_o | output | 1 | Integrate or discharge in progress |
| valid_o | output | 1 | One-clock strobe for a new reading |
| count_o | output | CNT_W | Reading magnitude |
| pol_o | output | 1 | Reading polarity, 1 = positive |
| ovr_o | output | 1 | Reading is an overrange |
| under_o | output | 1 | Reading is below the underrange threshold |

## Verification
The comparator is modelled as flipping a chosen number of clocks into discharge, with either input sign. This separates the counting path from the polarity latch and the reference select. The chosen counts straddle each threshold: zero, one below and at the underrange limit, exactly full scale, one past it, and well past it. These points separate an off-by-one in the count, in the overrange cut-off or in the underrange compare from a correct design. They also show whether the longer drain phase follows only an overrange. The spacing between integration starts, the null phase after reset and a hold/release sequence tell apart the cycle-fill logic, the minimum null time and the run gating.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_NULL  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DISCH = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;

  function automatic logic [3:0] phase_to_onehot(input phase_e ph);
    logic [3:0] oh;
    oh = 4'b0000;
    oh[ph] = 1'b1;
    return oh;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int INT_CLKS     = 10000,
  parameter int ZI_NORM_CLKS = 150,
  parameter int ZI_OVR_CLKS  = 6200,
  parameter int AZ_MIN_CLKS  = 10000,
  parameter int CYCLE_CLKS   = 50000
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run_i,
  input  logic   cmp_i,
  input  logic   disch_done_i,
  input  logic   disch_over_i,
  output phase_e state_q,
  output phase_e state_d,
  output logic   pol_q,
  output logic   pol_d
);

  localparam int TMR_MAX = max3(INT_CLKS, ZI_OVR_CLKS, max3(ZI_NORM_CLKS, AZ_MIN_CLKS, 1));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int CYC_W   = $clog2(CYCLE_CLKS + 1);

  localparam logic [TMR_W-1:0] INT_LAST  = TMR_W'(INT_CLKS - 1);
  localparam logic [TMR_W-1:0] ZIN_LAST  = TMR_W'(ZI_NORM_CLKS - 1);
  localparam logic [TMR_W-1:0] ZIO_LAST  = TMR_W'(ZI_OVR_CLKS - 1);
  localparam logic [TMR_W-1:0] AZ_LAST   = TMR_W'(AZ_MIN_CLKS - 1);
  localparam logic [TMR_W-1:0] TMR_SAT   = TMR_W'(TMR_MAX);
  localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(CYCLE_CLKS - 1);
  localparam logic [CYC_W-1:0] CYC_SAT   = CYC_W'(CYCLE_CLKS);

  logic [TMR_W-1:0] tmr_q;
  logic [CYC_W-1:0] cyc_q;
  logic             long_drain_q;
  logic             drain_end;
  logic             null_end;

  assign drain_end = long_drain_q ? (tmr_q == ZIO_LAST) : (tmr_q == ZIN_LAST);
  assign null_end  = run_i && (tmr_q >= AZ_LAST) && (cyc_q >= CYC_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_NULL:  if (null_end)            state_d = PH_INTEG;
      PH_INTEG: if (tmr_q == INT_LAST)   state_d = PH_DISCH;
      PH_DISCH: if (disch_done_i)        state_d = PH_DRAIN;
      PH_DRAIN: if (drain_end)           state_d = PH_NULL;
      default:                           state_d = PH_NULL;
    endcase
  end

  assign pol_d = (state_q == PH_INTEG && state_d == PH_DISCH) ? cmp_i : pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PH_NULL;
      tmr_q        <= '0;
      cyc_q        <= CYC_SAT;
      pol_q        <= 1'b0;
      long_drain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pol_q   <= pol_d;

      if (state_d != state_q)
        tmr_q <= '0;
      else if (tmr_q != TMR_SAT)
        tmr_q <= tmr_q + 1'b1;

      if (state_q == PH_NULL && state_d == PH_INTEG)
        cyc_q <= '0;
      else if (cyc_q != CYC_SAT)
        cyc_q <= cyc_q + 1'b1;

      if (state_q == PH_DISCH && state_d == PH_DRAIN)
        long_drain_q <= disch_over_i;
    end
  end

endmodule

// File: rtl/dsadc_disch_cnt.sv
module dsadc_disch_cnt #(
  parameter int FULL_SCALE = 20000,
  parameter int CNT_W      = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic             cmp_i,
  input  logic             pol_i,
  output logic             done_o,
  output logic             over_o,
  output logic [CNT_W-1:0] result_o
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FULL_SCALE);
  localparam logic [CNT_W-1:0] OVR_CNT  = CNT_W'(FULL_SCALE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             crossed;
  logic             at_last;

  assign crossed  = (cmp_i != pol_i);
  assign at_last  = (cnt_q == LAST_CNT);
  assign done_o   = active_i && (crossed || at_last);
  assign over_o   = active_i && !crossed && at_last;
  assign result_o = over_o ? OVR_CNT : cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active_i)
      cnt_q <= '0;
    else if (!at_last)
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg #(
  parameter int UNDER_LIM = 1800,
  parameter int CNT_W     = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] result_i,
  input  logic             over_i,
  input  logic             pol_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pol_o,
  output logic             ovr_o,
  output logic             under_o
);

  localparam logic [CNT_W-1:0] UNDER_CNT = CNT_W'(UNDER_LIM);

  logic under_d;
  assign under_d = !over_i && (result_i < UNDER_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      count_o <= '0;
      pol_o   <= 1'b0;
      ovr_o   <= 1'b0;
      under_o <= 1'b0;
    end else begin
      valid_o <= capture_i;
      if (capture_i) begin
        count_o <= result_i;
        pol_o   <= pol_i;
        ovr_o   <= over_i;
        under_o <= under_d;
      end
    end
  end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int FULL_SCALE   = 20000,
  parameter int INT_CLKS     = 10000,
  parameter int UNDER_LIM    = 1800,
  parameter int ZI_NORM_CLKS = 150,
  parameter int ZI_OVR_CLKS  = 6200,
  parameter int AZ_MIN_CLKS  = 10000,
  parameter int CYCLE_CLKS   = 50000,
  parameter int CNT_W        = $clog2(FULL_SCALE + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             cmp_i,
  output logic [3:0]       phase_oh_o,
  output logic             ref_neg_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pol_o,
  output logic             ovr_o,
  output logic             under_o
);

  phase_e           state_q, state_d;
  logic             pol_q, pol_d;
  logic             disch_done, disch_over;
  logic [CNT_W-1:0] disch_result;

  dsadc_phase_ctrl #(
    .INT_CLKS    (INT_CLKS),
    .ZI_NORM_CLKS(ZI_NORM_CLKS),
    .ZI_OVR_CLKS (ZI_OVR_CLKS),
    .AZ_MIN_CLKS (AZ_MIN_CLKS),
    .CYCLE_CLKS  (CYCLE_CLKS)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .cmp_i       (cmp_i),
    .disch_done_i(disch_done),
    .disch_over_i(disch_over),
    .state_q     (state_q),
    .state_d     (state_d),
    .pol_q       (pol_q),
    .pol_d       (pol_d)
  );

  dsadc_disch_cnt #(
    .FULL_SCALE(FULL_SCALE),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .active_i(state_q == PH_DISCH),
    .cmp_i   (cmp_i),
    .pol_i   (pol_q),
    .done_o  (disch_done),
    .over_o  (disch_over),
    .result_o(disch_result)
  );

  dsadc_result_reg #(
    .UNDER_LIM(UNDER_LIM),
    .CNT_W    (CNT_W)
  ) u_res (
    .clk      (clk),
    .rst      (rst),
    .capture_i(disch_done),
    .result_i (disch_result),
    .over_i   (disch_over),
    .pol_i    (pol_q),
    .valid_o  (valid_o),
    .count_o  (count_o),
    .pol_o    (pol_o),
    .ovr_o    (ovr_o),
    .under_o  (under_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_oh_o <= phase_to_onehot(PH_NULL);
      busy_o     <= 1'b0;
      ref_neg_o  <= 1'b0;
    end else begin
      phase_oh_o <= phase_to_onehot(state_d);
      busy_o     <= (state_d == PH_INTEG) || (state_d == PH_DISCH);
      ref_neg_o  <= (state_d == PH_DISCH) && pol_d;
    end
  end

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int FULL_SCALE = 20000,
  parameter int UNDER_LIM  = 1800,
  parameter int CNT_W      = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             run_i,
  input logic [3:0]       phase_oh_o,
  input logic             ref_neg_o,
  input logic             busy_o,
  input logic             valid_o,
  input logic [CNT_W-1:0] count_o,
  input logic             ovr_o,
  input logic             under_o
);

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_oh_o) == 1);

  a_r1_order: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_oh_o) |-> phase_oh_o == {$past(phase_oh_o[2:0]), $past(phase_oh_o[3])});

  a_r3_ref_in_disch: assert property (@(posedge clk) disable iff (rst)
    ref_neg_o |-> phase_oh_o[2]);

  a_r5_ovr_count: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> count_o == CNT_W'(FULL_SCALE + 1));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count_o <= CNT_W'(FULL_SCALE + 1));

  a_r6_under_flag: assert property (@(posedge clk) disable iff (rst)
    under_o |-> (!ovr_o && count_o < CNT_W'(UNDER_LIM)));

  a_r9_run_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_oh_o[1]) |-> $past(run_i));

  a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> phase_oh_o[1]);

  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r11_valid_drain: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> phase_oh_o[3]);

  a_r11_count_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(count_o));

endmodule

bind dsadc_seq dsadc_seq_chk #(
  .FULL_SCALE(FULL_SCALE),
  .UNDER_LIM (UNDER_LIM),
  .CNT_W     (CNT_W)
) u_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .run_i     (run_i),
  .phase_oh_o(phase_oh_o),
  .ref_neg_o (ref_neg_o),
  .busy_o    (busy_o),
  .valid_o   (valid_o),
  .count_o   (count_o),
  .ovr_o     (ovr_o),
  .under_o   (under_o)
);

// File: tb/test_dsadc_seq.sv
module test_dsadc_seq;

  localparam int FS     = 200;
  localparam int INTC   = 100;
  localparam int UNDER  = 18;
  localparam int ZIN    = 10;
  localparam int ZIO    = 40;
  localparam int AZMIN  = 50;
  localparam int CYC    = 400;
  localparam int CW     = $clog2(FS + 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_i = 1'b1;
  logic          cmp_i = 1'b0;
  logic [3:0]    phase_oh_o;
  logic          ref_neg_o, busy_o, valid_o, pol_o, ovr_o, under_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int failures = 0;
  int cycle_no = 0;
  int prev_int = 0;
  bit have_prev = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cycle_no <= cycle_no + 1;

  dsadc_seq #(
    .FULL_SCALE(FS), .INT_CLKS(INTC), .UNDER_LIM(UNDER),
    .ZI_NORM_CLKS(ZIN), .ZI_OVR_CLKS(ZIO), .AZ_MIN_CLKS(AZMIN), .CYCLE_CLKS(CYC)
  ) i_dsadc_seq (
    .clk(clk), .rst(rst), .run_i(run_i), .cmp_i(cmp_i),
    .phase_oh_o(phase_oh_o), .ref_neg_o(ref_neg_o), .busy_o(busy_o),
    .valid_o(valid_o), .count_o(count_o), .pol_o(pol_o),
    .ovr_o(ovr_o), .under_o(under_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "phase in reset", phase_oh_o, 1);
    chk("R12", "busy in reset", busy_o, 0);
    chk("R12", "valid in reset", valid_o, 0);
    chk("R12", "count in reset", count_o, 0);
    chk("R12", "flags in reset", {pol_o, ovr_o, under_o}, 0);
    rst = 1'b0;
    begin
      int k = 0;
      while (phase_oh_o[0]) begin
        k++;
        @(negedge clk);
      end
      chk("R8", "null length after reset", k, AZMIN);
    end
  endtask

  // One full conversion: sign of input, comparator flips n clocks into discharge
  task automatic conversion(input bit pos, input int n);
    bit over;
    int exp_cnt, ic, dc, zc;
    over    = (n > FS);
    exp_cnt = over ? FS + 1 : n;
    cmp_i   = pos;
    while (!phase_oh_o[1]) @(negedge clk);
    if (have_prev) chk("R8", "cycle spacing", cycle_no - prev_int, CYC);
    prev_int  = cycle_no;
    have_prev = 1;
    chk("R10", "busy in integrate", busy_o, 1);
    ic = 0;
    while (phase_oh_o[1]) begin
      ic++;
      @(negedge clk);
    end
    chk("R2", "integrate length", ic, INTC);
    chk("R1", "integrate followed by discharge", phase_oh_o, 4);
    chk("R10", "busy in discharge", busy_o, 1);
    chk("R3", "reference select", ref_neg_o, pos);
    dc = 0;
    while (phase_oh_o[2]) begin
      if (dc == n) cmp_i = ~cmp_i;
      if (dc > 0 && ref_neg_o != pos) chk("R3", "reference select held", ref_neg_o, pos);
      dc++;
      @(negedge clk);
    end
    chk(over ? "R5" : "R4", "discharge length", dc, over ? FS + 1 : n + 1);
    chk("R1", "discharge followed by drain", phase_oh_o, 8);
    chk("R11", "valid on first drain clock", valid_o, 1);
    chk("R10", "busy in drain", busy_o, 0);
    chk(over ? "R5" : "R4", "reading", count_o, exp_cnt);
    chk("R5", "overrange flag", ovr_o, over);
    chk("R6", "underrange flag", under_o, (!over && n < UNDER));
    chk("R3", "polarity", pol_o, pos);
    zc = 0;
    while (phase_oh_o[3]) begin
      if (zc == 1) chk("R11", "valid single clock", valid_o, 0);
      zc++;
      @(negedge clk);
    end
    chk("R7", "drain length", zc, over ? ZIO : ZIN);
    chk("R1", "drain followed by null", phase_oh_o, 1);
    cmp_i = pos;
  endtask

  task automatic hold_and_release();
    int held_cnt;
    bit bad_phase, bad_busy, bad_cnt;
    while (!phase_oh_o[1]) @(negedge clk);
    run_i = 1'b0;
    conversion_tail();
    held_cnt  = count_o;
    bad_phase = 0;
    bad_busy  = 0;
    bad_cnt   = 0;
    for (int i = 0; i < 700; i++) begin
      if (!phase_oh_o[0]) bad_phase = 1;
      if (busy_o) bad_busy = 1;
      if (count_o != held_cnt) bad_cnt = 1;
      @(negedge clk);
    end
    chk("R9", "parked in null while held", bad_phase, 0);
    chk("R9", "busy low while held", bad_busy, 0);
    chk("R9", "reading held", bad_cnt, 0);
    run_i = 1'b1;
    @(negedge clk);
    chk("R9", "integrate one clock after release", phase_oh_o, 2);
    have_prev = 0;
  endtask

  // finish a conversion already in integrate, comparator flipping at 60
  task automatic conversion_tail();
    int dc;
    while (phase_oh_o[1]) @(negedge clk);
    dc = 0;
    while (phase_oh_o[2]) begin
      if (dc == 60) cmp_i = ~cmp_i;
      dc++;
      @(negedge clk);
    end
    chk("R9", "held conversion completes", count_o, 60);
    while (phase_oh_o[3]) @(negedge clk);
  endtask

  initial begin
    do_reset();
    conversion(1'b1, 120);
    conversion(1'b0, 150);
    conversion(1'b1, 0);
    conversion(1'b0, UNDER - 1);
    conversion(1'b1, UNDER);
    conversion(1'b1, FS);
    conversion(1'b0, FS + 1);
    conversion(1'b1, 20);
    conversion(1'b1, 500);
    cmp_i = 1'b0;
    hold_and_release();
    conversion(1'b0, 75);
    conversion(1'b1, 90);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule